// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Ownership Parking

This block decides which of four bus masters may own a shared parallel bus. Each master has an active-low request line and receives an active-low grant line. The arbiter watches the shared FRAME_n and IRDY_n strobes to tell when the bus is idle. It serves competing requests in rotating order, so no master is starved.

When nobody else wants the bus, the grant stays with the present owner (parking). The owner may then start its next transaction without requesting again. Agents 0 to 2 are expansion slots and can be parked. Agent 3 is a legacy bridge, and its grant is withdrawn as soon as it stops requesting. When nothing is requesting and no grant is held, the grant parks on slot 0. Handing the grant from one master to another always passes through one cycle in which every grant line is high.

Top module: `pci_park_arbiter`

## Requirements
- R1: There are four agents, indexed 0 to 3, each with one bit in `req_n` and `gnt_n`. A low bit means request or grant. Agent 3 is the legacy bridge and agent 0 is the default parking slot.
- R2: While `rst_n` is low, every bit of `gnt_n` is high at once.
- R3: At most one bit of `gnt_n` is low in any cycle.
- R4: The grant never moves straight from one agent to another. Between two different grants there is at least one cycle with `gnt_n` equal to 4'b1111.
- R5: A new grant is asserted only at a clock edge where the bus is idle, meaning `frame_n` and `irdy_n` are both high. While the bus is busy and no grant is held, `gnt_n` stays 4'b1111.
- R6: A grant given to a requester goes to the first requesting agent found when searching upward, with wrap-around, from the rotation pointer. After a grant to agent k, the pointer becomes (k+1) mod 4. The pointer is 0 after reset.
- R7: An owner that is a slot agent (0 to 2) keeps its grant while no other agent requests, whether or not it is requesting itself.
- R8: When the bridge (agent 3) holds the grant and its request is high at a clock edge, its grant is high after that edge.
- R9: When another agent requests, the owner's grant is withdrawn at the next edge if the bus is idle or the owner's own request is high. Otherwise the owner keeps the grant.
- R10: When no grant is held, the bus is idle and no agent requests, slot 0 is granted at the next edge. This parking grant does not move the rotation pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low request, one bit per agent |
| frame_n | input | 1 | Shared active-low FRAME strobe |
| irdy_n | input | 1 | Shared active-low initiator-ready strobe |
| gnt_n | output | 4 | Active-low grant, one bit per agent |

## Verification
A corrupted rotation pointer shows up at the second grant after it goes wrong. That grant lands on the wrong agent as soon as two or more agents compete. A wrong owner or grant-valid bit shows up on `gnt_n` in the very next cycle, because the grant lines decode directly from those registers. A faulty idle or withdrawal decision shows up one edge after the stimulus. It appears as a grant that appears during a busy bus, disappears while parked, or moves without the all-high gap cycle. The stimulus sequence is built so that each of these cases occurs with a known expected grant pattern.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // next rotation index after agent i among n agents
  function automatic int unsigned wrap_inc(input int unsigned i, input int unsigned n);
    return (i + 1) % n;
  endfunction

  // wrapped distance from the pointer to agent i
  function automatic int unsigned ring_dist(input int unsigned ptr, input int unsigned i,
                                            input int unsigned n);
    return (i + n - ptr) % n;
  endfunction
endpackage

// File: rtl/pci_idle_mon.sv
module pci_idle_mon (
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle
);
  // bus idle when neither shared strobe is driven low
  assign bus_idle = frame_n & irdy_n;
endmodule

// File: rtl/pci_rr_pick.sv
module pci_rr_pick #(
  parameter int N_AG = 4,
  localparam int W = (N_AG > 1) ? $clog2(N_AG) : 1
) (
  input  logic [N_AG-1:0] req,
  input  logic [W-1:0]    ptr,
  output logic            any,
  output logic [W-1:0]    win
);
  // searched downward so the agent closest to the pointer is written last and wins
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = N_AG - 1; k >= 0; k--) begin
      int unsigned j;
      j = (int'(ptr) + k) % N_AG;
      if (req[j]) begin
        any = 1'b1;
        win = W'(j);
      end
    end
  end
endmodule

// File: rtl/pci_grant_fsm.sv
module pci_grant_fsm #(
  parameter int N_AG      = 4,
  parameter int BRIDGE_ID = 3,
  parameter int PARK_ID   = 0,
  localparam int W = (N_AG > 1) ? $clog2(N_AG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_AG-1:0] req,
  input  logic            bus_idle,
  input  logic            any,
  input  logic [W-1:0]    win,
  output logic            gnt_on,
  output logic [W-1:0]    owner,
  output logic [W-1:0]    ptr,
  output logic            drop_ev,
  output logic            issue_ev,
  output logic            park_ev
);
  logic [N_AG-1:0] others;
  logic            owner_req, other_req, owner_is_bridge;

  always_comb begin
    others        = req;
    others[owner] = 1'b0;
  end

  assign owner_req       = req[owner];
  assign other_req       = |others;
  assign owner_is_bridge = (int'(owner) == BRIDGE_ID);

  // withdrawal, new grant and default parking as named events
  assign drop_ev  = gnt_on && ((other_req && (bus_idle || !owner_req)) ||
                               (owner_is_bridge && !owner_req));
  assign issue_ev = !gnt_on && bus_idle && any;
  assign park_ev  = !gnt_on && bus_idle && !any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_on <= 1'b0;
      owner  <= W'(PARK_ID);
      ptr    <= '0;
    end else if (drop_ev) begin
      gnt_on <= 1'b0;
    end else if (issue_ev) begin
      gnt_on <= 1'b1;
      owner  <= win;
      ptr    <= W'(arb_pkg::wrap_inc(int'(win), N_AG));
    end else if (park_ev) begin
      gnt_on <= 1'b1;
      owner  <= W'(PARK_ID);
    end
  end

  // R6: pointer lands just past the agent that won
  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev |=> (int'(ptr) == int'(arb_pkg::wrap_inc(int'($past(win)), N_AG))));

  // R10: default parking leaves the pointer where it was
  assert_park_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    park_ev |=> ($stable(ptr) && gnt_on && (int'(owner) == PARK_ID)));

  // R7: a slot owner with no competition stays parked
  assert_slot_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_on && !owner_is_bridge && !other_req) |=> (gnt_on && $stable(owner)));
endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter #(
  parameter int N_AG      = 4,
  parameter int BRIDGE_ID = 3,
  parameter int PARK_ID   = 0,
  localparam int W = (N_AG > 1) ? $clog2(N_AG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_AG-1:0] req_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  output logic [N_AG-1:0] gnt_n
);
  logic [N_AG-1:0] req;
  logic            bus_idle, any, gnt_on, drop_ev, issue_ev, park_ev;
  logic [W-1:0]    win, owner, ptr;

  assign req = ~req_n;

  pci_idle_mon u_idle (.frame_n(frame_n), .irdy_n(irdy_n), .bus_idle(bus_idle));

  pci_rr_pick #(.N_AG(N_AG)) u_pick (.req(req), .ptr(ptr), .any(any), .win(win));

  pci_grant_fsm #(.N_AG(N_AG), .BRIDGE_ID(BRIDGE_ID), .PARK_ID(PARK_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle), .any(any), .win(win),
    .gnt_on(gnt_on), .owner(owner), .ptr(ptr),
    .drop_ev(drop_ev), .issue_ev(issue_ev), .park_ev(park_ev));

  // one decoded grant line per agent
  for (genvar g = 0; g < N_AG; g++) begin : g_gnt
    assign gnt_n[g] = !(gnt_on && (int'(owner) == g));
  end

  // R3: never two grants at once
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R4: a held grant either stays put or goes fully away
  assert_gap_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~gnt_n)) |=> ((&gnt_n) || $stable(gnt_n)));

  // R5: no grant appears while the bus is busy
  assert_grant_on_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gnt_n) && !(frame_n && irdy_n)) |=> (&gnt_n));

  // R8: bridge is never left parked
  assert_bridge_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_n[BRIDGE_ID] && req_n[BRIDGE_ID]) |=> gnt_n[BRIDGE_ID]);
endmodule

// File: tb/sim_pci_park_arbiter.sv
module sim_pci_park_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'b1111;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [3:0] gnt_n;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pci_park_arbiter u0 (.clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
                       .irdy_n(irdy_n), .gnt_n(gnt_n));

  // {req_n, frame_n, irdy_n, expected gnt_n after the next edge}
  localparam int NV = 25;
  localparam logic [9:0] VEC [NV] = '{
    {4'b1111, 1'b1, 1'b1, 4'b1110},  // 0  R10 park on slot 0
    {4'b1101, 1'b1, 1'b1, 4'b1111},  // 1  R9 idle, other requests
    {4'b1101, 1'b1, 1'b1, 4'b1101},  // 2  R6 agent 1 wins
    {4'b1101, 1'b0, 1'b1, 4'b1101},  // 3  R9 sole requester keeps
    {4'b1001, 1'b0, 1'b0, 4'b1101},  // 4  R9 busy, owner still asks
    {4'b1001, 1'b1, 1'b1, 4'b1111},  // 5  R4 gap
    {4'b1001, 1'b1, 1'b1, 4'b1011},  // 6  R6 agent 2
    {4'b1111, 1'b1, 1'b1, 4'b1011},  // 7  R7 parked on slot
    {4'b0111, 1'b1, 1'b1, 4'b1111},  // 8  R9
    {4'b0111, 1'b0, 1'b1, 4'b1111},  // 9  R5 busy, no new grant
    {4'b0111, 1'b1, 1'b1, 4'b0111},  // 10 R1 bridge
    {4'b1111, 1'b0, 1'b1, 4'b1111},  // 11 R8 bridge released
    {4'b1111, 1'b1, 1'b1, 4'b1110},  // 12 R10
    {4'b0100, 1'b1, 1'b1, 4'b1111},  // 13 R9
    {4'b0100, 1'b1, 1'b1, 4'b1110},  // 14 R10 pointer was not moved
    {4'b0100, 1'b1, 1'b1, 4'b1111},  // 15 R4
    {4'b0100, 1'b1, 1'b1, 4'b1101},  // 16 R6
    {4'b0100, 1'b1, 1'b1, 4'b1111},  // 17 R4
    {4'b0100, 1'b1, 1'b1, 4'b0111},  // 18 R6 skips idle agent 2
    {4'b0100, 1'b1, 1'b1, 4'b1111},  // 19 R9
    {4'b0100, 1'b1, 1'b1, 4'b1110},  // 20 R6 wrap to 0
    {4'b1110, 1'b0, 1'b1, 4'b1110},  // 21 R7
    {4'b1011, 1'b0, 1'b0, 4'b1111},  // 22 R9 owner dropped request
    {4'b1011, 1'b0, 1'b0, 4'b1111},  // 23 R5
    {4'b1011, 1'b1, 1'b1, 4'b1011}   // 24 R6 from pointer 1
  };
  localparam string TAG [NV] = '{
    "R10", "R9", "R6", "R9", "R9", "R4", "R6", "R7", "R9", "R5", "R1", "R8", "R10",
    "R9", "R10", "R4", "R6", "R4", "R6", "R9", "R6", "R7", "R9", "R5", "R6"};

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s gnt_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // per-cycle watch of R3 and R4 at the ports
  logic [3:0] prev_g = 4'b1111;
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      n_checks++;
      if ($countones(~gnt_n) > 1) begin
        n_fail++;
        $display("FAIL R3 gnt_n actual=%b expected=at most one low", gnt_n);
      end
      if (prev_g != 4'b1111 && gnt_n != 4'b1111 && gnt_n != prev_g) begin
        n_fail++;
        $display("FAIL R4 gnt_n actual=%b expected=1111 or %b", gnt_n, prev_g);
      end
    end
    prev_g = gnt_n;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R2", gnt_n, 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {req_n, frame_n, irdy_n} = VEC[i][9:4];
      @(posedge clk);
      #2;
      check(TAG[i], gnt_n, VEC[i][3:0]);
      @(negedge clk);
    end
    // R2: reset in mid-grant drops every grant immediately
    rst_n = 1'b0;
    #1;
    check("R2", gnt_n, 4'b1111);
    req_n = 4'b1010; frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    // R6: pointer back to 0 after reset, agent 0 first
    @(posedge clk); #2;
    check("R6", gnt_n, 4'b1110);
    @(negedge clk);
    @(posedge clk); #2;
    check("R9", gnt_n, 4'b1111);
    @(negedge clk);
    @(posedge clk); #2;
    check("R6", gnt_n, 4'b1011);
    @(negedge clk);
    // R7: slot owner stays parked with no request for many cycles
    req_n = 4'b1111;
    repeat (5) begin
      @(posedge clk); #2;
      check("R7", gnt_n, 4'b1011);
      @(negedge clk);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule